// File: doc/BRIEF.md
# Generation-Bit Event Queue Reader

This block is the consumer side of a circular event queue kept in a small memory of 32-bit words. The producer writes entries and marks each one with a generation bit in the top position (bit 31). The reader does not count entries to know whether the queue is empty. It keeps its own read index and a one-bit lap toggle. An entry is new only when its top bit differs from the toggle. The toggle inverts each time the index wraps to slot zero, so entries left over from the previous lap read as empty without any extra bookkeeping.

The reader drives the memory read address from its current index and takes the read word when a request arrives while the memory reports valid data. One cycle later it reports the result: a result strobe, a flag that says whether the entry was new, and the 31-bit payload, which is zero when there was no new entry. A consume moves the index forward past a new entry. A peek reports the entry but leaves the index and toggle unchanged. The depth is a power-of-two parameter, two or more.

Top module: `genq_reader`

## Requirements
- R1: After reset the read index is 0 and the lap toggle is 0, so with an all-zero memory an accepted request reports no new entry.
- R2: `rd_addr_o` always presents the current read index, in the range 0 to DEPTH-1.
- R3: An entry whose bit 31 equals the lap toggle is stale: the result has `res_new_o`=0 and `res_payload_o`=0.
- R4: An entry whose bit 31 differs from the lap toggle is new: the result has `res_new_o`=1 and `res_payload_o` equal to bits 30:0 of the entry.
- R5: A consume (request with `peek_i`=0) of a new entry moves the index to (index+1) AND (DEPTH-1).
- R6: When a consume moves the index from DEPTH-1 to 0, the lap toggle inverts, so the same bit-31 value that was new on the previous lap is stale on the next one.
- R7: A peek (request with `peek_i`=1) reports the entry as in R3/R4 but changes neither the index nor the toggle.
- R8: A request that finds a stale entry leaves the index and toggle unchanged, whether it is a peek or a consume.
- R9: A request is accepted only in a cycle with `req_i`=1 and `rd_ready_i`=1; `res_valid_o` is 1 exactly in the cycle after an accepted request, and a cycle with no accepted request changes neither index nor toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Read request |
| peek_i | input | 1 | 1: look without consuming; 0: consume |
| rd_ready_i | input | 1 | Memory read data for `rd_addr_o` is available this cycle |
| rd_addr_o | output | IDX_W | Memory read address (current index) |
| rd_data_i | input | 32 | Memory read word; bit 31 is the generation bit |
| res_valid_o | output | 1 | Result strobe, one cycle after an accepted request |
| res_new_o | output | 1 | The read entry was new |
| res_payload_o | output | 31 | Entry bits 30:0 when new, else zero |

## Verification
The index step and the lap-toggle inversion fall in the same cycle when a new entry in the last slot is consumed, and the next validity decision then depends on both. The bench fills whole laps with entries of one generation value and consumes through slot DEPTH-1, then checks that the entry at slot 0 with the unchanged top bit now reads as stale, while random requests mix peeks, stalls and producer rewrites around the wrap. A result is judged against a bench model of index and toggle that is advanced by its own rules, comparing the address, the new flag and the payload.

// File: rtl/genq_pkg.sv
package genq_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned PAY_W  = WORD_W - 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [PAY_W-1:0]  payload_t;

  // Next slot on a power-of-two ring.
  function automatic int unsigned ring_step(int unsigned idx, int unsigned depth);
    return (idx + 1) & (depth - 1);
  endfunction

  // An entry is new when its generation bit differs from the lap toggle.
  function automatic logic gen_fresh(word_t w, logic lap);
    return w[WORD_W-1] != lap;
  endfunction

  function automatic payload_t gen_payload(word_t w, logic fresh);
    return fresh ? w[PAY_W-1:0] : '0;
  endfunction

endpackage

// File: rtl/genq_ptr.sv
module genq_ptr #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             lap_o,
  output logic             wrap_o
);
  import genq_pkg::*;

  logic [IDX_W-1:0] idx_q;
  logic             lap_q;
  logic [IDX_W-1:0] idx_nxt;

  assign idx_nxt = IDX_W'(ring_step(32'(idx_q), DEPTH));
  assign wrap_o  = adv_i && (idx_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      lap_q <= 1'b0;
    end else if (adv_i) begin
      idx_q <= idx_nxt;
      if (idx_nxt == '0) lap_q <= ~lap_q;
    end
  end

  assign idx_o = idx_q;
  assign lap_o = lap_q;

endmodule

// File: rtl/genq_eval.sv
module genq_eval (
  input  genq_pkg::word_t    word_i,
  input  logic               lap_i,
  output logic               fresh_o,
  output genq_pkg::payload_t payload_o
);
  import genq_pkg::*;

  always_comb begin
    fresh_o   = gen_fresh(word_i, lap_i);
    payload_o = gen_payload(word_i, fresh_o);
  end

endmodule

// File: rtl/genq_reader.sv
module genq_reader #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             peek_i,
  input  logic             rd_ready_i,
  output logic [IDX_W-1:0] rd_addr_o,
  input  logic [31:0]      rd_data_i,
  output logic             res_valid_o,
  output logic             res_new_o,
  output logic [30:0]      res_payload_o
);
  import genq_pkg::*;

  generate
    if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("genq_reader: DEPTH must be a power of two and at least 2");
    end
  endgenerate

  // Named internal events, used by the bound checker.
  logic     accept_w;
  logic     fresh_w;
  logic     adv_w;
  logic     wrap_w;
  logic     lap_w;
  payload_t pay_w;

  assign accept_w = req_i && rd_ready_i;
  assign adv_w    = accept_w && fresh_w && !peek_i;

  genq_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (adv_w),
    .idx_o  (rd_addr_o),
    .lap_o  (lap_w),
    .wrap_o (wrap_w)
  );

  genq_eval u_eval (
    .word_i    (rd_data_i),
    .lap_i     (lap_w),
    .fresh_o   (fresh_w),
    .payload_o (pay_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o   <= 1'b0;
      res_new_o     <= 1'b0;
      res_payload_o <= '0;
    end else begin
      res_valid_o <= accept_w;
      if (accept_w) begin
        res_new_o     <= fresh_w;
        res_payload_o <= pay_w;
      end
    end
  end

endmodule

// File: rtl/genq_reader_chk.sv
module genq_reader_chk #(
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             peek,
  input logic             fresh,
  input logic             wrap,
  input logic [IDX_W-1:0] addr,
  input logic             res_valid,
  input logic             res_new,
  input logic [30:0]      res_payload
);

  // R9
  strobe_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);

  // R9
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !res_valid && $stable(addr));

  // R7
  peek_holds_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && peek) |=> $stable(addr));

  // R8
  stale_holds_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !fresh) |=> $stable(addr));

  // R5
  consume_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fresh && !peek) |=> addr == IDX_W'($past(addr) + 1'b1));

  // R6
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> addr == '0);

  // R3
  stale_zero_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_new) |-> res_payload == '0);

endmodule

bind genq_reader genq_reader_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept_w),
  .peek        (peek_i),
  .fresh       (fresh_w),
  .wrap        (wrap_w),
  .addr        (rd_addr_o),
  .res_valid   (res_valid_o),
  .res_new     (res_new_o),
  .res_payload (res_payload_o)
);

// File: tb/genq_reader_tb_top.sv
`timescale 1ns/1ps
module genq_reader_tb_top;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, peek = 1'b0, rdy = 1'b0;
  logic [IDX_W-1:0] rd_addr;
  logic [31:0] rd_data;
  logic res_valid, res_new;
  logic [30:0] res_payload;

  logic [31:0] mem [DEPTH];
  assign rd_data = mem[rd_addr];

  always #10 clk = ~clk;

  genq_reader #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .peek_i(peek), .rd_ready_i(rdy),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .res_valid_o(res_valid),
    .res_new_o(res_new), .res_payload_o(res_payload)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int unsigned m_idx = 0;
  bit m_lap = 0;

  function automatic int unsigned nxt(int unsigned i);
    return (i == DEPTH - 1) ? 0 : i + 1;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(bit r, bit p, bit y, string tag);
    bit acc, e_new;
    logic [30:0] e_pay;
    req = r; peek = p; rdy = y;
    chk(rd_addr == IDX_W'(m_idx), "R2 addr", rd_addr, m_idx);
    acc   = r && y;
    e_new = mem[m_idx][31] != m_lap;
    e_pay = e_new ? mem[m_idx][30:0] : 31'd0;
    @(negedge clk);
    chk(res_valid == acc, "R9 valid", res_valid, acc);
    if (acc) begin
      chk(res_new == e_new, {tag, " new"}, res_new, e_new);
      chk(res_payload == e_pay, {tag, " payload"}, res_payload, e_pay);
      if (e_new && !p) begin
        m_idx = nxt(m_idx);
        if (m_idx == 0) m_lap = !m_lap;
      end
    end
    chk(rd_addr == IDX_W'(m_idx), {tag, " index"}, rd_addr, m_idx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < DEPTH; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(res_valid == 1'b0, "R1 valid", res_valid, 0);
    chk(rd_addr == '0, "R1 addr", rd_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1, 0, 1, "R1 zero queue");
    chk(res_new == 1'b0, "R1 empty", res_new, 0);
    step(1, 0, 0, "R9 not ready");
    step(0, 0, 1, "R9 no req");
    // fill a lap with generation 1
    for (int i = 0; i < DEPTH; i++) mem[i] = {1'b1, 31'(32'h100 + i)};
    step(1, 1, 1, "R7 peek");
    step(1, 1, 1, "R7 peek again");
    for (int i = 0; i < DEPTH; i++) step(1, 0, 1, "R4 R5 consume");
    chk(rd_addr == '0, "R6 wrapped", rd_addr, 0);
    step(1, 0, 1, "R6 old lap stale");
    chk(res_new == 1'b0, "R6 stale after wrap", res_new, 0);
    step(1, 1, 1, "R8 peek stale");
    // next lap written with generation 0
    for (int i = 0; i < DEPTH; i++) mem[i] = {1'b0, 31'(32'h7fff_ff00 + i)};
    for (int i = 0; i < DEPTH; i++) step(1, 0, 1, "R4 R6 lap two");
    step(1, 0, 1, "R3 R8 stale");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 4) == 0) mem[$urandom % DEPTH] = $urandom;
      step(($urandom % 4) != 0, ($urandom % 4) == 0, ($urandom % 3) != 0, "R3 R4 R5 R7 R9 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule